// File: doc/BRIEF.md
# Transmit Impedance Calibration Calculator

This block converts the N-side and P-side impedance codes reported by a transmit calibration engine into six driver-segment enable codes: a margin select, a pre-emphasis select and a total-enable value for each side. A request names one pair of links. When that pair has not been calibrated yet, the block raises a level request toward the calibration engine. It holds that request until the engine reports completion, and then accepts the two codes in that same cycle.

Both codes are range-checked. The arithmetic is carried out in wide unsigned fixed point using two parameters: the margin ratio `M` and the pre-emphasis coefficient `K0`. Each result is reduced by dropping nine fractional bits with round-half-up. A flag is kept for each pair of links and stays set once that pair calibrates successfully. After that, any further request from the pair completes at once and leaves the stored results untouched.

Top module: `tximp_calc`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `done`, `error` and `calReq` are 0, all six result fields are 0, and every pair counts as uncalibrated.
- R2: A `start` accepted in idle for an uncalibrated pair raises `calReq` from the next cycle on. `calReq` stays high until a cycle in which `calDone` is sampled high.
- R3: When `calDone` is sampled together with `calErr`, the next cycle shows `done`=1 and `error`=1. The result fields are unchanged, and the pair stays uncalibrated, so a later request raises `calReq` again.
- R4: Each code is accepted only from 80 to 320 inclusive. If either code lies outside that range when `calDone` is sampled, the block reports `done`=1 and `error`=1 and leaves all result fields unchanged.
- R5: margin = ((128 − M) × code) / 2, using integer division; the field is round(margin).
- R6: pre = ((128 × code − 2 × margin) × K0) / 128, using integer division; the field is round(pre).
- R7: total = 128 × code − 2 × margin − (pre AND 1023); the field is round(total). With M=128 and K0=0, N code 0xDA and P code 0xC7 give totalEnN=0x37 and totalEnP=0x32, and all margin and pre fields are 0.
- R8: round(x) = (x >> 9) + bit 8 of x. The result is truncated to `ENC_W` bits.
- R9: With valid codes and no `calErr`, the cycle after `calDone` is sampled shows the new fields, `done`=1, `error`=0 and `calReq`=0. `done` lasts exactly one cycle.
- R10: A `start` for a pair that has already calibrated successfully gives `done`=1 and `error`=0 in the next cycle. It never raises `calReq`, and the result fields are unchanged.
- R11: Each pair has its own completion flag. A successful calibration of one pair does not let another pair skip its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| pairSel | input | $clog2(NUM_PAIRS) | Link pair the request belongs to |
| zcalN | input | CODE_W | Measured N-side impedance code |
| zcalP | input | CODE_W | Measured P-side impedance code |
| calDone | input | 1 | Calibration engine finished |
| calErr | input | 1 | Calibration engine reports a fault, valid with calDone |
| calReq | output | 1 | Calibration request to the engine |
| totalEnN | output | ENC_W | N-side total-enable code |
| totalEnP | output | ENC_W | P-side total-enable code |
| preN | output | ENC_W | N-side pre-emphasis select |
| preP | output | ENC_W | P-side pre-emphasis select |
| marginN | output | ENC_W | N-side margin select |
| marginP | output | ENC_W | P-side margin select |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |

## Verification
A wrong per-pair completion flag shows up on the very next request from that pair. Either `calReq` rises when it should not, or `done` arrives one cycle early with no request at all. An arithmetic or rounding fault shows up in the result fields in the cycle after `calDone`. A second instance with non-default `M` and `K0` makes the margin and pre-emphasis paths nonzero, so faults in those paths are visible. A fault that loads results on a rejected code, or clears them wrongly, is seen at the next completion. At that point the held fields must equal the last accepted set.

// File: rtl/tximp_pkg.sv
package tximp_pkg;
  // Fractional bits removed by the final rounding step
  localparam int ZC_FRAC = 9;
  // Fixed-point unit used by the margin and pre-emphasis formulas
  localparam int ZC_UNIT_SHIFT = 7;
  // Inclusive acceptance window for a measured code
  localparam int ZC_CODE_MIN = 10 << 3;
  localparam int ZC_CODE_MAX = 40 << 3;
  // Mask applied to the pre-emphasis term before it is subtracted
  localparam int ZC_PRE_MASK = 1023;

  typedef struct packed {
    logic loadRes;   // capture both sides' results this cycle
  } ctrlStrb_t;
endpackage

// File: rtl/tximp_side_calc.sv
module tximp_side_calc
  import tximp_pkg::*;
#(
  parameter int CODE_W  = 9,
  parameter int ENC_W   = 7,
  parameter int ARITH_W = 24,
  parameter int M       = 128,
  parameter int K0      = 0
) (
  input  logic [CODE_W-1:0] code,
  output logic              rangeOk,
  output logic [ENC_W-1:0]  marginEnc,
  output logic [ENC_W-1:0]  preEnc,
  output logic [ENC_W-1:0]  totalEnc
);
  localparam logic [CODE_W-1:0]  LO_LIM   = CODE_W'(ZC_CODE_MIN);
  localparam logic [CODE_W-1:0]  HI_LIM   = CODE_W'(ZC_CODE_MAX);
  localparam logic [ARITH_W-1:0] MARG_F   = ARITH_W'(128 - M);
  localparam logic [ARITH_W-1:0] K0_F     = ARITH_W'(K0);
  localparam logic [ARITH_W-1:0] PRE_MSK  = ARITH_W'(ZC_PRE_MASK);

  function automatic logic [ARITH_W-1:0] roundDrop(input logic [ARITH_W-1:0] v);
    return (v >> ZC_FRAC) + ARITH_W'(v[ZC_FRAC-1]);
  endfunction

  logic [ARITH_W-1:0] wideCode;
  logic [ARITH_W-1:0] scaled;
  logic [ARITH_W-1:0] marginRaw;
  logic [ARITH_W-1:0] marginDbl;
  logic [ARITH_W-1:0] preRaw;
  logic [ARITH_W-1:0] totalRaw;

  always_comb begin
    wideCode  = ARITH_W'(code);
    scaled    = wideCode << ZC_UNIT_SHIFT;
    marginRaw = (MARG_F * wideCode) >> 1;
    marginDbl = marginRaw << 1;
    preRaw    = ((scaled - marginDbl) * K0_F) >> ZC_UNIT_SHIFT;
    totalRaw  = scaled - marginDbl - (preRaw & PRE_MSK);
  end

  assign rangeOk   = (code >= LO_LIM) && (code <= HI_LIM);
  assign marginEnc = ENC_W'(roundDrop(marginRaw));
  assign preEnc    = ENC_W'(roundDrop(preRaw));
  assign totalEnc  = ENC_W'(roundDrop(totalRaw));
endmodule

// File: rtl/tximp_datapath.sv
module tximp_datapath
  import tximp_pkg::*;
#(
  parameter int CODE_W  = 9,
  parameter int ENC_W   = 7,
  parameter int ARITH_W = 24,
  parameter int M       = 128,
  parameter int K0      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [CODE_W-1:0] codeIn [2],
  output logic              rangeOk,
  output logic [ENC_W-1:0]  marginQ [2],
  output logic [ENC_W-1:0]  preQ [2],
  output logic [ENC_W-1:0]  totalQ [2]
);
  localparam int SIDES = 2;

  logic [SIDES-1:0] sideOk;
  logic [ENC_W-1:0] marginD [SIDES];
  logic [ENC_W-1:0] preD [SIDES];
  logic [ENC_W-1:0] totalD [SIDES];

  // Index 0 is the N side, index 1 the P side
  for (genvar s = 0; s < SIDES; s++) begin : gSide
    tximp_side_calc #(
      .CODE_W(CODE_W), .ENC_W(ENC_W), .ARITH_W(ARITH_W), .M(M), .K0(K0)
    ) uCalc (
      .code      (codeIn[s]),
      .rangeOk   (sideOk[s]),
      .marginEnc (marginD[s]),
      .preEnc    (preD[s]),
      .totalEnc  (totalD[s])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        marginQ[s] <= '0;
        preQ[s]    <= '0;
        totalQ[s]  <= '0;
      end else if (strb.loadRes) begin
        marginQ[s] <= marginD[s];
        preQ[s]    <= preD[s];
        totalQ[s]  <= totalD[s];
      end
    end

    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadRes |=> $stable(totalQ[s]) && $stable(preQ[s]) && $stable(marginQ[s])); // R4
  end

  assign rangeOk = &sideOk;
endmodule

// File: rtl/tximp_control.sv
module tximp_control
  import tximp_pkg::*;
#(
  parameter int NUM_PAIRS = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [$clog2(NUM_PAIRS)-1:0] pairSel,
  input  logic                         calDone,
  input  logic                         calErr,
  input  logic                         rangeOk,
  output ctrlStrb_t                    strb,
  output logic                         calReq,
  output logic                         done,
  output logic                         error
);
  localparam int PAIR_W = $clog2(NUM_PAIRS);

  typedef enum logic {ST_IDLE, ST_POLL} ctlState_t;

  ctlState_t         state;
  logic [PAIR_W-1:0] activePair;
  logic [NUM_PAIRS-1:0] calibrated;
  logic              doneR;
  logic              errR;
  logic              accept;

  assign accept       = (state == ST_POLL) && calDone;
  assign strb.loadRes = accept && !calErr && rangeOk;
  assign calReq       = (state == ST_POLL);
  assign done         = doneR;
  assign error        = errR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      activePair <= '0;
      calibrated <= '0;
      doneR      <= 1'b0;
      errR       <= 1'b0;
    end else begin
      doneR <= 1'b0;
      errR  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (calibrated[pairSel]) begin
              doneR <= 1'b1;
            end else begin
              state      <= ST_POLL;
              activePair <= pairSel;
            end
          end
        end
        ST_POLL: begin
          if (calDone) begin
            state <= ST_IDLE;
            doneR <= 1'b1;
            if (calErr || !rangeOk) errR <= 1'b1;
            else calibrated[activePair] <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    calReq && !calDone |=> calReq); // R2
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    calReq && calDone |=> !calReq && done); // R9
  AST_CAL_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    calReq && calDone && calErr |=> error); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done); // R4
  AST_STICKY_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && start && calibrated[pairSel] |=> done && !error && !calReq); // R10
endmodule

// File: rtl/tximp_calc.sv
module tximp_calc
  import tximp_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int CODE_W    = 9,
  parameter int ENC_W     = 7,
  parameter int ARITH_W   = 24,
  parameter int M         = 128,
  parameter int K0        = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [$clog2(NUM_PAIRS)-1:0] pairSel,
  input  logic [CODE_W-1:0]            zcalN,
  input  logic [CODE_W-1:0]            zcalP,
  input  logic                         calDone,
  input  logic                         calErr,
  output logic                         calReq,
  output logic [ENC_W-1:0]             totalEnN,
  output logic [ENC_W-1:0]             totalEnP,
  output logic [ENC_W-1:0]             preN,
  output logic [ENC_W-1:0]             preP,
  output logic [ENC_W-1:0]             marginN,
  output logic [ENC_W-1:0]             marginP,
  output logic                         done,
  output logic                         error
);
  ctrlStrb_t        strb;
  logic             rangeOk;
  logic [CODE_W-1:0] codes [2];
  logic [ENC_W-1:0] marginQ [2];
  logic [ENC_W-1:0] preQ [2];
  logic [ENC_W-1:0] totalQ [2];

  assign codes[0] = zcalN;
  assign codes[1] = zcalP;

  tximp_control #(.NUM_PAIRS(NUM_PAIRS)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .pairSel (pairSel),
    .calDone (calDone),
    .calErr  (calErr),
    .rangeOk (rangeOk),
    .strb    (strb),
    .calReq  (calReq),
    .done    (done),
    .error   (error)
  );

  tximp_datapath #(
    .CODE_W(CODE_W), .ENC_W(ENC_W), .ARITH_W(ARITH_W), .M(M), .K0(K0)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .codeIn  (codes),
    .rangeOk (rangeOk),
    .marginQ (marginQ),
    .preQ    (preQ),
    .totalQ  (totalQ)
  );

  assign totalEnN = totalQ[0];
  assign totalEnP = totalQ[1];
  assign preN     = preQ[0];
  assign preP     = preQ[1];
  assign marginN  = marginQ[0];
  assign marginP  = marginQ[1];
endmodule

// File: tb/tximp_calc_test.sv
`timescale 1ns/1ps
module tximp_calc_test;
  localparam int TUNED_M  = 112;
  localparam int TUNED_K0 = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [0:0] pairSel = '0;
  logic [8:0] zcalN = '0;
  logic [8:0] zcalP = '0;
  logic calDone = 1'b0;
  logic calErr = 1'b0;

  logic reqA, doneA, errA, reqB, doneB, errB;
  logic [6:0] tnA, tpA, pnA, ppA, mnA, mpA;
  logic [6:0] tnB, tpB, pnB, ppB, mnB, mpB;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tximp_calc uut (
    .clk(clk), .rstN(rstN), .start(start), .pairSel(pairSel),
    .zcalN(zcalN), .zcalP(zcalP), .calDone(calDone), .calErr(calErr),
    .calReq(reqA), .totalEnN(tnA), .totalEnP(tpA), .preN(pnA), .preP(ppA),
    .marginN(mnA), .marginP(mpA), .done(doneA), .error(errA)
  );

  tximp_calc #(.M(TUNED_M), .K0(TUNED_K0)) uutTuned (
    .clk(clk), .rstN(rstN), .start(start), .pairSel(pairSel),
    .zcalN(zcalN), .zcalP(zcalP), .calDone(calDone), .calErr(calErr),
    .calReq(reqB), .totalEnN(tnB), .totalEnP(tpB), .preN(pnB), .preP(ppB),
    .marginN(mnB), .marginP(mpB), .done(doneB), .error(errB)
  );

  typedef struct {
    logic        err;
    logic [41:0] vecA;
    logic [41:0] vecB;
    string       tag;
  } expItem_t;

  expItem_t   sbQueue[$];
  logic [41:0] lastA, lastB;
  bit         stickyM[2];

  function automatic int rnd(input int x);
    return (x >> 9) + ((x >> 8) & 1);
  endfunction

  // Fields packed as {total, pre, margin} for the given code
  function automatic logic [20:0] sideModel(input int z, input int m, input int k0);
    int margin, base, pre, total;
    margin = ((128 - m) * z) / 2;
    base   = 128 * z;
    pre    = ((base - 2 * margin) * k0) / 128;
    total  = base - 2 * margin - (pre & 1023);
    return {7'(rnd(total)), 7'(rnd(pre)), 7'(rnd(margin))};
  endfunction

  function automatic logic [41:0] fullModel(input int zn, input int zp, input int m, input int k0);
    logic [20:0] n, p;
    n = sideModel(zn, m, k0);
    p = sideModel(zp, m, k0);
    return {n[20:14], p[20:14], n[13:7], p[13:7], n[6:0], p[6:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && doneA) begin
      if (sbQueue.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 64'(doneA), 64'd0);
      end else begin
        expItem_t e;
        e = sbQueue.pop_front();
        check(errA === e.err, e.tag, "error", 64'(errA), 64'(e.err));
        check({tnA, tpA, pnA, ppA, mnA, mpA} === e.vecA, e.tag, "fields default",
              64'({tnA, tpA, pnA, ppA, mnA, mpA}), 64'(e.vecA));
        check(doneB === 1'b1 && errB === e.err, e.tag, "tuned done/error",
              64'({doneB, errB}), 64'({1'b1, e.err}));
        check({tnB, tpB, pnB, ppB, mnB, mpB} === e.vecB, e.tag, "fields tuned",
              64'({tnB, tpB, pnB, ppB, mnB, mpB}), 64'(e.vecB));
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(doneA === 1'b0 && errA === 1'b0 && reqA === 1'b0, "R1", "ctrl in reset",
          64'({doneA, errA, reqA}), 64'd0);
    check({tnA, tpA, pnA, ppA, mnA, mpA, tnB, tpB, mnB, mpB, pnB, ppB} === '0, "R1",
          "fields in reset", 64'({tnA, tpA, pnA, ppA, mnA, mpA}), 64'd0);
    rstN = 1'b1;
    stickyM[0] = 0;
    stickyM[1] = 0;
    lastA = '0;
    lastB = '0;
    @(negedge clk);
    check(doneA === 1'b0 && reqA === 1'b0, "R1", "after reset", 64'({doneA, reqA}), 64'd0);
  endtask

  task automatic calibrate(input int pair, input int zn, input int zp, input bit perr,
                           input string tag);
    expItem_t e;
    bit fast, good;
    fast = stickyM[pair];
    good = !fast && !perr && zn >= 80 && zn <= 320 && zp >= 80 && zp <= 320;
    if (good) begin
      lastA = fullModel(zn, zp, 128, 0);
      lastB = fullModel(zn, zp, TUNED_M, TUNED_K0);
      stickyM[pair] = 1;
    end
    e.err  = !fast && !good;
    e.vecA = lastA;
    e.vecB = lastB;
    e.tag  = tag;
    sbQueue.push_back(e);

    start   = 1'b1;
    pairSel = 1'(pair);
    @(negedge clk);
    start = 1'b0;
    if (fast) begin
      check(reqA === 1'b0 && doneA === 1'b1, "R10", "fast path req/done",
            64'({reqA, doneA}), 64'b01);
    end else begin
      check(reqA === 1'b1 && reqB === 1'b1, "R2", "calReq raised", 64'(reqA), 64'd1);
      repeat (2) begin
        @(negedge clk);
        check(reqA === 1'b1 && doneA === 1'b0, "R2", "calReq held", 64'({reqA, doneA}), 64'b10);
      end
      zcalN   = 9'(zn);
      zcalP   = 9'(zp);
      calErr  = perr;
      calDone = 1'b1;
      @(negedge clk);
      calDone = 1'b0;
      calErr  = 1'b0;
      check(reqA === 1'b0 && doneA === 1'b1, "R9", "req released with done",
            64'({reqA, doneA}), 64'b01);
    end
    @(negedge clk);
    check(doneA === 1'b0 && reqA === 1'b0, "R9", "done single cycle", 64'({doneA, reqA}), 64'd0);
  endtask

  initial begin
    lastA = '0;
    lastB = '0;
    stickyM[0] = 0;
    stickyM[1] = 0;
    doReset();

    calibrate(0, 'hDA, 'hC7, 1'b0, "R7");
    check(tnA === 7'h37 && tpA === 7'h32 && pnA === 0 && ppA === 0 && mnA === 0 && mpA === 0,
          "R7", "example values", 64'({tnA, tpA}), 64'h1BB2);
    calibrate(0, 300, 100, 1'b0, "R10");
    calibrate(1, 200, 200, 1'b1, "R3");
    calibrate(1, 200, 200, 1'b0, "R11");
    calibrate(1, 150, 150, 1'b0, "R10");

    doReset();
    calibrate(1, 79, 200, 1'b0, "R4");
    calibrate(1, 200, 321, 1'b0, "R4");
    calibrate(1, 80, 320, 1'b0, "R4");
    calibrate(0, 81, 0, 1'b0, "R4");

    doReset();
    calibrate(0, 81, 255, 1'b0, "R8");
    check(tnA === 7'd20, "R8", "round down case", 64'(tnA), 64'd20);
    for (int i = 0; i < 6; i++) begin
      doReset();
      calibrate(i % 2, 90 + 37 * i, 310 - 41 * i, 1'b0, (i % 2) ? "R5" : "R6");
    end

    repeat (3) @(negedge clk);
    check(sbQueue.size() == 0, "R9", "all results seen", 64'(sbQueue.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule